// File: doc/BRIEF.md
# Channel-Aware Audio Sample FIFO

This block holds audio sample words for the playback direction of a serial audio port. A register-side writer pushes sample words into a circular RAM, and the serializer pops them one word per request. The RAM size comes from a 3-bit size code, starting at 256 words and doubling per code step. The block adapts its usable depth to the configured channel count. Per-channel depth is the RAM size divided by the channel count rounded up to the next power of two, so odd channel counts leave part of the RAM idle.

Software sees a status word with the fill level counted in whole frames and two sticky error flags, one for overrun and one for underrun. A control write can empty the storage and can enable a half-full interrupt request. Samples are either 24-bit words or 16-bit samples placed in the upper part of the 24-bit word. Size code and channel count are sampled only at reset or on a clear.

Top module: `chan_sample_fifo`

## Requirements
- R1: After a clear, the block accepts exactly L words, where L = ((256 << code) >> u) * n. Here n is the channel count (0 is taken as 1, above 8 as 8). The value u is 0 for n = 1, 1 for n = 2, 2 for n = 3..4 and 3 for n = 5..8.
- R2: With 3 channels the depth uses 4-channel units: size code 0 gives 64 frames (192 words).
- R3: `st_rdata[16:8]` holds the stored word count divided by the channel count, rounded down, saturating at 511. All other status bits except bits 4 and 0 read zero.
- R4: A host write while L words are stored is dropped and sets the sticky overrun flag at `st_rdata[4]`.
- R5: A serializer read while empty sets the sticky underrun flag at `st_rdata[0]` and loads zero onto `ser_data`.
- R6: A status write ANDs the overrun flag with `st_ovr_keep` and the underrun flag with `st_udr_keep`. Writing both as 0 clears both flags, and writing 1 leaves a flag as it is. An error event in the same cycle wins.
- R7: A control write with `ctl_clear` = 1 empties the storage in that cycle and leaves the error flags unchanged. The clear does not persist: a later control write with `ctl_clear` = 0 does not empty the storage.
- R8: Each control write loads the half-full enable from `ctl_half_irq_en`. `irq` is high while the enable is set and the stored word count is at most L/2.
- R9: With `host_w16` = 0 the word stored is `host_wdata[23:0]`. With `host_w16` = 1 the stored word is `host_wdata[15:0]` placed at bits 23:8 with zeros below. `ser_data16` always shows `ser_data[23:8]`.
- R10: Words leave in write order. A popped word appears on `ser_data` in the cycle after the read request and holds until the next read request.
- R11: A change of `cfg_size_code` or `cfg_chans` takes effect only at reset or on a clear.
- R12: A size code above the parameter MAX_CODE (default 1) acts as MAX_CODE. With the default setting, code 7 gives 512 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_code | input | 3 | RAM size code, sampled on reset or clear |
| cfg_chans | input | 4 | Channel count 1..8, sampled on reset or clear |
| ctl_we | input | 1 | Control write strobe |
| ctl_clear | input | 1 | Control write: empty the storage |
| ctl_half_irq_en | input | 1 | Control write: half-full request enable |
| st_we | input | 1 | Status write strobe |
| st_ovr_keep | input | 1 | Status write: 0 clears overrun |
| st_udr_keep | input | 1 | Status write: 0 clears underrun |
| st_rdata | output | 24 | Status word: frames at 16:8, overrun at 4, underrun at 0 |
| host_we | input | 1 | Host sample write strobe |
| host_w16 | input | 1 | Host sample is 16-bit |
| host_wdata | input | 24 | Host sample data |
| ser_rd | input | 1 | Serializer read request |
| ser_data | output | 24 | Last popped word |
| ser_data16 | output | 16 | Last popped word as a 16-bit sample |
| irq | output | 1 | Half-full interrupt request, level |

## Verification
The hardest situation to reach is a configuration change that has been applied to the inputs but not yet taken through a clear. In that state the old capacity limit must still govern overrun while the new size code waits. The stimulus fills the FIFO under 2-channel settings and then sets size code 7 with 1 channel without clearing. It fills up to the old limit and shows that the next write overruns there. Only after a clear does it show the saturated 512-word capacity, with the frame field capped at 511.

// File: rtl/csf_pkg.sv
package csf_pkg;

    localparam int unsigned WORD_W    = 24;
    localparam int unsigned BASE_LOG2 = 8;
    localparam int unsigned FIELD_MAX = 511;

    typedef struct packed {
        logic [2:0] code;
        logic [3:0] chans;
    } csf_cfg_t;

    typedef struct packed {
        logic ovr;
        logic udr;
    } csf_err_t;

    function automatic logic [3:0] clamp_chans(input logic [3:0] c);
        if (c == 4'd0)      return 4'd1;
        else if (c > 4'd8)  return 4'd8;
        else                return c;
    endfunction

    function automatic logic [1:0] unit_log2(input logic [3:0] c);
        if (c <= 4'd1)      return 2'd0;
        else if (c == 4'd2) return 2'd1;
        else if (c <= 4'd4) return 2'd2;
        else                return 2'd3;
    endfunction

    function automatic logic [15:0] words_to_frames(input logic [15:0] w,
                                                    input logic [3:0]  c);
        case (c)
            4'd2:    return w >> 1;
            4'd3:    return w / 16'd3;
            4'd4:    return w >> 2;
            4'd5:    return w / 16'd5;
            4'd6:    return w / 16'd6;
            4'd7:    return w / 16'd7;
            4'd8:    return w >> 3;
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/csf_store.sv
module csf_store
    import csf_pkg::*;
#(
    parameter int unsigned AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [2:0]        code,
    input  logic              wr_ok,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_req,
    input  logic              rd_ok,
    output logic [WORD_W-1:0] q
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr, mask;
    logic [AW:0]       span;

    always_comb begin
        span = (AW+1)'(1) << (BASE_LOG2 + int'(code));
        mask = AW'(span - (AW+1)'(1));
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            q    <= '0;
        end else begin
            if (rd_ok)       q <= mem[rptr];
            else if (rd_req) q <= '0;
            if (clr) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (wr_ok) wptr <= (wptr + AW'(1)) & mask;
                if (rd_ok) rptr <= (rptr + AW'(1)) & mask;
            end
        end
    end
endmodule

// File: rtl/csf_level.sv
module csf_level
    import csf_pkg::*;
#(
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  csf_cfg_t      cfg,
    input  logic          wr_ok,
    input  logic          rd_ok,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] limit,
    output logic          full,
    output logic          empty,
    output logic          half
);
    logic [CW-1:0] cap, unit;

    always_comb begin
        cap   = CW'(1) << (BASE_LOG2 + int'(cfg.code));
        unit  = cap >> unit_log2(cfg.chans);
        limit = unit * {{(CW-4){1'b0}}, cfg.chans};
        full  = (cnt >= limit);
        empty = (cnt == '0);
        half  = (cnt <= (limit >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else begin
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/chan_sample_fifo.sv
module chan_sample_fifo
    import csf_pkg::*;
#(
    parameter int unsigned MAX_CODE = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cfg_size_code,
    input  logic [3:0]  cfg_chans,
    input  logic        ctl_we,
    input  logic        ctl_clear,
    input  logic        ctl_half_irq_en,
    input  logic        st_we,
    input  logic        st_ovr_keep,
    input  logic        st_udr_keep,
    output logic [23:0] st_rdata,
    input  logic        host_we,
    input  logic        host_w16,
    input  logic [23:0] host_wdata,
    input  logic        ser_rd,
    output logic [23:0] ser_data,
    output logic [15:0] ser_data16,
    output logic        irq
);
    localparam int unsigned AW = BASE_LOG2 + MAX_CODE;
    localparam int unsigned CW = AW + 1;

    csf_cfg_t          in_cfg, act_cfg;
    csf_err_t          err_q;
    logic              irq_en, clr_cmd;
    logic              wr_ok, rd_ok, ovr_evt, udr_evt;
    logic              full, empty, half;
    logic [CW-1:0]     cnt, limit;
    logic [WORD_W-1:0] wr_word;
    logic [15:0]       frames;
    logic [8:0]        field;

    always_comb begin
        in_cfg.code  = (cfg_size_code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : cfg_size_code;
        in_cfg.chans = clamp_chans(cfg_chans);
        clr_cmd = ctl_we & ctl_clear;
        wr_ok   = host_we & ~full  & ~clr_cmd;
        rd_ok   = ser_rd  & ~empty & ~clr_cmd;
        ovr_evt = host_we & full  & ~clr_cmd;
        udr_evt = ser_rd  & empty & ~clr_cmd;
        wr_word = host_w16 ? {host_wdata[15:0], 8'h00} : host_wdata;
        frames  = words_to_frames(16'(cnt), act_cfg.chans);
        field   = (frames > 16'(FIELD_MAX)) ? 9'(FIELD_MAX) : frames[8:0];
        st_rdata   = {7'd0, field, 3'd0, err_q.ovr, 3'd0, err_q.udr};
        ser_data16 = ser_data[23:8];
        irq        = irq_en & half;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg <= in_cfg;
            err_q   <= '0;
            irq_en  <= 1'b0;
        end else begin
            if (clr_cmd) act_cfg <= in_cfg;
            if (ctl_we)  irq_en  <= ctl_half_irq_en;
            err_q.ovr <= ovr_evt | (err_q.ovr & ~(st_we & ~st_ovr_keep));
            err_q.udr <= udr_evt | (err_q.udr & ~(st_we & ~st_udr_keep));
        end
    end

    csf_level #(.CW(CW)) u_level (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_cmd),
        .cfg   (act_cfg),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok),
        .cnt   (cnt),
        .limit (limit),
        .full  (full),
        .empty (empty),
        .half  (half)
    );

    csf_store #(.AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_cmd),
        .code    (act_cfg.code),
        .wr_ok   (wr_ok),
        .wr_word (wr_word),
        .rd_req  (ser_rd),
        .rd_ok   (rd_ok),
        .q       (ser_data)
    );
endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
    parameter int unsigned CW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          host_we,
    input logic          ser_rd,
    input logic          clr,
    input logic          ctl_we,
    input logic          ctl_half_irq_en,
    input logic          st_we,
    input logic          st_ovr_keep,
    input logic          st_udr_keep,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] limit,
    input logic          full,
    input logic          empty,
    input logic          ovr,
    input logic          udr,
    input logic [23:0]   ser_data,
    input logic          irq
);
    // R1: storage never holds more than the usable limit
    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);

    // R4: a write at the limit is dropped and flags overrun
    p_drop_when_full_r4: assert property (@(posedge clk) disable iff (rst)
        host_we && full && !ser_rd && !clr |=> $stable(cnt) && ovr);

    // R5: a read while empty yields zero and flags underrun
    p_empty_read_r5: assert property (@(posedge clk) disable iff (rst)
        ser_rd && empty && !clr |=> (ser_data == 24'd0) && udr);

    // R6: a status write of zeros wipes both flags when no event occurs
    p_flag_wipe_r6: assert property (@(posedge clk) disable iff (rst)
        st_we && !st_ovr_keep && !st_udr_keep && !host_we && !ser_rd |=> !ovr && !udr);

    // R7: a clear empties the storage
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

    // R8: disabling the request drops it in the next cycle
    p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_we && !ctl_half_irq_en |=> !irq);
endmodule

bind chan_sample_fifo csf_checker #(.CW(CW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .host_we         (host_we),
    .ser_rd          (ser_rd),
    .clr             (clr_cmd),
    .ctl_we          (ctl_we),
    .ctl_half_irq_en (ctl_half_irq_en),
    .st_we           (st_we),
    .st_ovr_keep     (st_ovr_keep),
    .st_udr_keep     (st_udr_keep),
    .cnt             (cnt),
    .limit           (limit),
    .full            (full),
    .empty           (empty),
    .ovr             (err_q.ovr),
    .udr             (err_q.udr),
    .ser_data        (ser_data),
    .irq             (irq)
);

// File: tb/chan_sample_fifo_test.sv
module chan_sample_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_size_code = 3'd0;
    logic [3:0]  cfg_chans = 4'd1;
    logic        ctl_we = 1'b0, ctl_clear = 1'b0, ctl_half_irq_en = 1'b0;
    logic        st_we = 1'b0, st_ovr_keep = 1'b0, st_udr_keep = 1'b0;
    logic [23:0] st_rdata;
    logic        host_we = 1'b0, host_w16 = 1'b0;
    logic [23:0] host_wdata = '0;
    logic        ser_rd = 1'b0;
    logic [23:0] ser_data;
    logic [15:0] ser_data16;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_sample_fifo uut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ctl(input logic clr, input logic hen);
        @(negedge clk);
        ctl_we = 1'b1; ctl_clear = clr; ctl_half_irq_en = hen;
        @(posedge clk); #1;
        ctl_we = 1'b0; ctl_clear = 1'b0; ctl_half_irq_en = 1'b0;
    endtask

    task automatic wstat(input logic keep_o, input logic keep_u);
        @(negedge clk);
        st_we = 1'b1; st_ovr_keep = keep_o; st_udr_keep = keep_u;
        @(posedge clk); #1;
        st_we = 1'b0;
    endtask

    task automatic push(input logic [23:0] d, input logic w16);
        @(negedge clk);
        host_we = 1'b1; host_wdata = d; host_w16 = w16;
        @(posedge clk); #1;
        host_we = 1'b0; host_w16 = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        ser_rd = 1'b1;
        @(posedge clk); #1;
        ser_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R3 reset status", st_rdata, 24'h0);
        check("R8 reset irq", {23'd0, irq}, 24'h0);
        check("R10 reset data", ser_data, 24'h0);
    endtask

    task automatic t_align();
        ctl(1'b1, 1'b0);
        push(24'hCDEF12, 1'b0);
        push(24'hAA1234, 1'b1);
        check("R3 two frames", st_rdata, 24'h000200);
        pop();
        check("R9 R10 24-bit word", ser_data, 24'hCDEF12);
        @(negedge clk);
        check("R10 data held", ser_data, 24'hCDEF12);
        pop();
        check("R9 16-bit word", ser_data, 24'h123400);
        check("R9 16-bit view", {8'd0, ser_data16}, 24'h001234);
    endtask

    task automatic t_underrun();
        pop();
        check("R5 empty read data", ser_data, 24'h0);
        check("R5 underrun flag", st_rdata, 24'h000001);
        wstat(1'b1, 1'b1);
        check("R6 keep flags", st_rdata, 24'h000001);
        wstat(1'b0, 1'b0);
        check("R6 zero clears", st_rdata, 24'h0);
    endtask

    task automatic t_capacity();
        int bad = 0;
        for (int i = 0; i < 256; i++) push(24'(i), 1'b0);
        check("R1 full 256 no overrun", st_rdata, 24'h010000);
        push(24'h0003E7, 1'b0);
        check("R4 overrun on full", st_rdata, 24'h010010);
        for (int i = 0; i < 256; i++) begin
            pop();
            if (ser_data !== 24'(i)) bad++;
        end
        check("R10 order of 256 words", 24'(bad), 24'h0);
        check("R4 dropped word absent", st_rdata, 24'h000010);
        wstat(1'b0, 1'b0);
    endtask

    task automatic t_three_ch();
        cfg_chans = 4'd3;
        ctl(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) push(24'(i), 1'b0);
        check("R3 floor of 4/3", st_rdata, 24'h000100);
        for (int i = 0; i < 196; i++) push(24'(i), 1'b0);
        check("R2 64 frames then overrun", st_rdata, 24'h004010);
        wstat(1'b0, 1'b0);
    endtask

    task automatic t_half();
        cfg_chans = 4'd2;
        ctl(1'b1, 1'b1);
        check("R8 irq when empty", {23'd0, irq}, 24'h1);
        for (int i = 0; i < 128; i++) push(24'(i), 1'b0);
        check("R8 irq at half", {23'd0, irq}, 24'h1);
        push(24'h0, 1'b0);
        check("R8 irq above half", {23'd0, irq}, 24'h0);
        ctl(1'b0, 1'b0);
        check("R7 clear bit not sticky", st_rdata, 24'h004000);
        ctl(1'b0, 1'b1);
        check("R8 enabled, above half", {23'd0, irq}, 24'h0);
        pop();
        check("R8 back to half", {23'd0, irq}, 24'h1);
    endtask

    task automatic t_config();
        cfg_size_code = 3'd7;
        cfg_chans = 4'd1;
        for (int i = 0; i < 128; i++) push(24'(i), 1'b0);
        check("R11 old limit still full", st_rdata, 24'h008000);
        push(24'h0, 1'b0);
        check("R11 overrun at old limit", st_rdata, 24'h008010);
        wstat(1'b0, 1'b0);
        ctl(1'b1, 1'b0);
        for (int i = 0; i < 512; i++) push(24'(i), 1'b0);
        check("R12 R3 512 words, field saturates", st_rdata, 24'h01FF00);
        push(24'h0, 1'b0);
        check("R12 overrun past 512", st_rdata, 24'h01FF10);
        ctl(1'b1, 1'b0);
        check("R7 clear keeps flags", st_rdata, 24'h000010);
        check("R8 irq off after disable", {23'd0, irq}, 24'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_align();
        t_underrun();
        t_capacity();
        t_three_ch();
        t_half();
        t_config();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule